// File: doc/BRIEF.md
# Precise exception commit unit

This block keeps the exception state of a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback. Each instruction carries its own fault code and PC down the pipe. A fault can be seen in fetch (bad fetch address), in decode (illegal opcode), in execute (arithmetic overflow) or in memory (bad data address). No fault acts where it is found. Every fault is acted on only when the instruction reaches the commit point, which is the memory stage.

At commit the unit decides whether the instruction retires or traps. A trap has two possible sources: a recorded fault, or an external interrupt that is injected at this point. When a trap is taken, the unit does the following:
- records a cause code and the exception PC;
- blocks the writeback of the committing instruction;
- discards the younger instructions in flight;
- masks interrupts and enters supervisor mode;
- points fetch at a fixed handler address.

A return-from-supervisor pulse unmasks interrupts and returns the unit to user mode. The surrounding pipeline advances one stage per clock, and instructions enter the unit from fetch.

Top module: `exc_commit`

## Requirements
- R1: After reset the unit is in supervisor mode with interrupts masked, `cause` and `epc` are zero, and `trap` and `wb_en` are low.
- R2: An instruction presented at `if_valid`/`if_pc` on a clock edge is in the commit stage three edges later. In that cycle, if it does not trap, `wb_en` is high and `wb_pc` shows its PC. Back-to-back instructions retire in order, one per cycle.
- R3: A fault is acted on only in the commit cycle, through `trap`. On the following edge, `cause` takes the code and `epc` takes the PC of the trapping instruction. The codes are: 1 = fetch fault, 2 = illegal opcode, 3 = overflow, 4 = data fault, 5 = interrupt.
- R4: When one instruction has faults in several stages, the cause recorded is the one from the earliest stage. The order is fetch, then decode, then execute, then memory.
- R5: `irq` causes a trap with code 5 only when interrupts are enabled and a valid instruction is in the commit stage. In that case it wins over any fault of that instruction. A masked `irq`, or an `irq` during a bubble, has no effect.
- R6: In the trap cycle `wb_en` is low. The two younger instructions in flight never retire, and any fault flags driven for them are ignored.
- R7: While `trap` is high, `redirect_pc` equals the handler address parameter.
- R8: A trap clears `irq_en` and sets `supervisor` on the next edge. Faults still trap while interrupts are masked.
- R9: A one-cycle `sret` pulse in a cycle without a trap sets `irq_en` and clears `supervisor` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | A fetched instruction enters decode at this edge |
| if_pc | input | XLEN | PC of the fetched instruction |
| if_fault | input | 1 | Fetch address fault for the fetched instruction |
| id_illegal | input | 1 | Illegal opcode for the instruction in decode |
| ex_overflow | input | 1 | Overflow for the instruction in execute |
| mem_fault | input | 1 | Data address fault for the instruction at commit |
| irq | input | 1 | External interrupt request (level) |
| sret | input | 1 | Return from supervisor |
| wb_en | output | 1 | Committing instruction may write architectural state |
| wb_pc | output | XLEN | PC of the instruction at commit |
| trap | output | 1 | Trap taken: kill all stages and redirect fetch |
| redirect_pc | output | XLEN | Handler address for fetch |
| cause | output | 3 | Recorded trap cause |
| epc | output | XLEN | PC of the first instruction not completed |
| irq_en | output | 1 | Interrupts enabled |
| supervisor | output | 1 | Supervisor mode |

## Verification
The checker assumes that each stage fault input is driven only in the cycle when the instruction it belongs to occupies that stage. It also assumes that `sret` is never raised in the same cycle as a trap, because in that case the trap would win. The bench meets both assumptions. It drives every fault flag from a per-instruction schedule shifted by the stage depth. It issues bursts of at most three instructions, so the younger instructions behind a trap are always still in flight and are killed. It pulses `sret` only when the pipeline is empty.

// File: rtl/exc_commit.sv
module exc_commit #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [XLEN-1:0] if_pc,
  input  logic            if_fault,
  input  logic            id_illegal,
  input  logic            ex_overflow,
  input  logic            mem_fault,
  input  logic            irq,
  input  logic            sret,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_pc,
  output logic            trap,
  output logic [XLEN-1:0] redirect_pc,
  output logic [2:0]      cause,
  output logic [XLEN-1:0] epc,
  output logic            irq_en,
  output logic            supervisor
);
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_FETCH = 3'd1;
  localparam logic [2:0] C_ILL   = 3'd2;
  localparam logic [2:0] C_OVF   = 3'd3;
  localparam logic [2:0] C_DATA  = 3'd4;
  localparam logic [2:0] C_IRQ   = 3'd5;

  logic            d_v, e_v, m_v;
  logic [2:0]      d_c, e_c, m_c;
  logic [XLEN-1:0] d_pc, e_pc, m_pc;
  logic [2:0]      m_eff;
  logic            irq_take;

  assign m_eff       = (m_c != C_NONE) ? m_c : (mem_fault ? C_DATA : C_NONE);
  assign irq_take    = irq & irq_en & m_v;
  assign trap        = irq_take | (m_v & (m_eff != C_NONE));
  assign wb_en       = m_v & ~trap;
  assign wb_pc       = m_pc;
  assign redirect_pc = HANDLER_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {d_v, e_v, m_v} <= '0;
      {d_c, e_c, m_c} <= '0;
      d_pc <= '0; e_pc <= '0; m_pc <= '0;
      cause <= C_NONE;
      epc <= '0;
      irq_en <= 1'b0;
      supervisor <= 1'b1;
    end else if (trap) begin
      {d_v, e_v, m_v} <= '0;
      cause <= irq_take ? C_IRQ : m_eff;
      epc <= m_pc;
      irq_en <= 1'b0;
      supervisor <= 1'b1;
    end else begin
      d_v  <= if_valid;
      d_pc <= if_pc;
      d_c  <= if_fault ? C_FETCH : C_NONE;
      e_v  <= d_v;
      e_pc <= d_pc;
      e_c  <= (d_c != C_NONE) ? d_c : (id_illegal ? C_ILL : C_NONE);
      m_v  <= e_v;
      m_pc <= e_pc;
      m_c  <= (e_c != C_NONE) ? e_c : (ex_overflow ? C_OVF : C_NONE);
      if (sret) begin
        irq_en <= 1'b1;
        supervisor <= 1'b0;
      end
    end
  end
endmodule

module exc_commit_sva #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            sret,
  input logic            wb_en,
  input logic [XLEN-1:0] wb_pc,
  input logic            trap,
  input logic [2:0]      cause,
  input logic [XLEN-1:0] epc,
  input logic            irq_en,
  input logic            supervisor
);
  a_r6_no_wb_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !wb_en);
  a_r6_younger_killed: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !wb_en && !trap);
  a_r8_trap_masks: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !irq_en && supervisor);
  a_r3_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> epc == $past(wb_pc) && cause != 3'd0);
  a_r5_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap && irq && irq_en |=> cause == 3'd5);
  a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
    sret && !trap |=> irq_en && !supervisor);
endmodule

bind exc_commit exc_commit_sva #(.XLEN(XLEN)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sret(sret), .wb_en(wb_en),
  .wb_pc(wb_pc), .trap(trap), .cause(cause), .epc(epc),
  .irq_en(irq_en), .supervisor(supervisor)
);

// File: tb/exc_commit_tb.sv
module exc_commit_tb;
  localparam logic [31:0] VEC = 32'h100;

  logic clk = 0, rst_n = 0;
  logic if_valid = 0, if_fault = 0, id_illegal = 0, ex_overflow = 0;
  logic mem_fault = 0, irq = 0, sret = 0;
  logic [31:0] if_pc = 0;
  logic wb_en, trap, irq_en, supervisor;
  logic [31:0] wb_pc, redirect_pc, epc;
  logic [2:0] cause;

  exc_commit #(.XLEN(32), .HANDLER_PC(VEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_overflow(ex_overflow),
    .mem_fault(mem_fault), .irq(irq), .sret(sret), .wb_en(wb_en),
    .wb_pc(wb_pc), .trap(trap), .redirect_pc(redirect_pc), .cause(cause),
    .epc(epc), .irq_en(irq_en), .supervisor(supervisor));

  always #4 clk = ~clk;

  typedef struct { bit is_trap; logic [31:0] pc; logic [2:0] code; } exp_t;
  exp_t q[$];
  exp_t got;
  int checks = 0, errors = 0;
  bit ie_model = 0, done = 0, pend = 0;
  logic [31:0] pend_pc;
  logic [2:0]  pend_code;

  logic [31:0] b_pc [3];
  bit b_ff[3], b_il[3], b_ov[3], b_df[3], b_irq[3];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic set_item(int j, logic [31:0] pc, bit ff, bit il, bit ov, bit df, bit iq);
    b_pc[j] = pc; b_ff[j] = ff; b_il[j] = il; b_ov[j] = ov; b_df[j] = df; b_irq[j] = iq;
  endtask

  task automatic burst(int n);
    bit stop = 0;
    for (int j = 0; j < n; j++) begin
      if (!stop) begin
        exp_t e;
        e.pc = b_pc[j];
        e.code = (b_irq[j] && ie_model) ? 3'd5 : b_ff[j] ? 3'd1 : b_il[j] ? 3'd2 :
                 b_ov[j] ? 3'd3 : b_df[j] ? 3'd4 : 3'd0;
        e.is_trap = (e.code != 0);
        q.push_back(e);
        if (e.is_trap) begin stop = 1; ie_model = 0; end
      end
    end
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if_valid    = (c < n);
      if_pc       = (c < n) ? b_pc[c] : 32'h0;
      if_fault    = (c < n) ? b_ff[c] : 1'b0;
      id_illegal  = (c >= 1 && c - 1 < n) ? b_il[c-1] : 1'b0;
      ex_overflow = (c >= 2 && c - 2 < n) ? b_ov[c-2] : 1'b0;
      mem_fault   = (c >= 3 && c - 3 < n) ? b_df[c-3] : 1'b0;
      irq         = (c >= 3 && c - 3 < n) ? b_irq[c-3] : 1'b0;
    end
    @(negedge clk);
    {if_valid, if_fault, id_illegal, ex_overflow, mem_fault, irq} = '0;
    if_pc = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_sret();
    @(negedge clk); sret = 1;
    @(negedge clk); sret = 0;
    ie_model = 1;
    #3;
    chk(irq_en === 1'b1, "R9 irq_en", irq_en, 1);
    chk(supervisor === 1'b0, "R9 supervisor", supervisor, 0);
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      if (pend) begin
        pend = 0;
        chk(cause === pend_code, "R3 R4 R5 cause", cause, pend_code);
        chk(epc === pend_pc, "R3 epc", epc, pend_pc);
        chk(irq_en === 1'b0 && supervisor === 1'b1, "R8 masked supervisor",
            {irq_en, supervisor}, 2'b01);
      end
      if (trap || wb_en) begin
        if (q.size() == 0) begin
          chk(0, "R6 unexpected event", {trap, wb_en, wb_pc[29:0]}, 0);
        end else begin
          got = q.pop_front();
          chk(trap === got.is_trap, "R2 R3 retire-or-trap", trap, got.is_trap);
          chk(wb_pc === got.pc, "R2 commit pc", wb_pc, got.pc);
          if (trap) begin
            chk(!wb_en, "R6 wb blocked", wb_en, 0);
            chk(redirect_pc === VEC, "R7 handler", redirect_pc, VEC);
            pend = 1; pend_pc = got.pc; pend_code = got.code;
          end
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk(supervisor === 1'b1 && irq_en === 1'b0, "R1 mode", {supervisor, irq_en}, 2'b10);
    chk(cause === 3'd0 && epc === 32'h0, "R1 regs", {cause, epc[28:0]}, 0);
    chk(!trap && !wb_en, "R1 outputs", {trap, wb_en}, 0);
    @(negedge clk); rst_n = 1;

    // R5: masked interrupt ignored
    set_item(0, 32'h1000, 0, 0, 0, 0, 1);
    burst(1);
    do_sret();
    // R2: back-to-back retirement
    set_item(0, 32'h2000, 0, 0, 0, 0, 0);
    set_item(1, 32'h2004, 0, 0, 0, 0, 0);
    set_item(2, 32'h2008, 0, 0, 0, 0, 0);
    burst(3);
    // R6: younger killed, its flags ignored
    set_item(0, 32'h3000, 0, 0, 0, 0, 0);
    set_item(1, 32'h3004, 0, 0, 1, 0, 0);
    set_item(2, 32'h3008, 0, 1, 0, 1, 1);
    burst(3);
    // R8: fault traps while masked
    set_item(0, 32'h4000, 0, 1, 0, 0, 0);
    burst(1);
    do_sret();
    // R4: earliest stage wins
    set_item(0, 32'h5000, 1, 1, 0, 1, 0);
    burst(1);
    do_sret();
    set_item(0, 32'h6000, 0, 1, 1, 0, 0);
    burst(1);
    do_sret();
    set_item(0, 32'h6100, 0, 0, 1, 1, 0);
    burst(1);
    do_sret();
    set_item(0, 32'h6200, 0, 0, 0, 1, 0);
    burst(1);
    do_sret();
    // R5: interrupt overrides data fault
    set_item(0, 32'h7000, 0, 0, 0, 1, 1);
    burst(1);
    do_sret();
    // R5: interrupt during bubbles has no effect
    @(negedge clk); irq = 1;
    repeat (4) @(negedge clk);
    irq = 0;
    #3;
    chk(irq_en === 1'b1 && supervisor === 1'b0, "R5 idle irq ignored",
        {irq_en, supervisor}, 2'b10);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R2 all expected events seen", q.size(), 0);
    finish_run();
  end
endmodule